// File: doc/BRIEF.md
# Single-Pulse Output Compare Unit

This block turns a free-running timer count into exactly one output pulse. Software picks one of two external timer counts as the time base and loads a leading-edge compare value and a trailing-edge compare value. It then writes the one-shot mode code into the control word. The output goes high on the clock after the selected count equals the leading-edge value. It goes low again on the clock after the count equals the trailing-edge value. After that the unit stays quiet until the mode is written again.

The trailing-edge event sets a sticky flag. Software clears the flag with a write-one-to-clear access. An interrupt request is the flag qualified by an interrupt enable bit in the control word. Re-arming needs only a new mode write: the timer may keep running and need not be cleared. The timers, their prescalers and the interrupt controller sit outside this block.

Top module: `sp_ocmp`

## Requirements
- R1: After reset, `pulse_o`, `irq_flag_o` and `irq_o` are all 0.
- R2: A write to address 0 whose bits [2:0] equal 3'b100 arms the unit, and `pulse_o` is 0 on the cycle after that write.
- R3: When the unit is armed and enabled, and the selected count equals the leading compare value (address 1) at a clock edge, `pulse_o` is 1 after that edge.
- R4: When the output is high and enabled, and the selected count equals the trailing compare value (address 2) at a clock edge, `pulse_o` is 0 and `irq_flag_o` is 1 after that edge.
- R5: After the trailing edge, no further pulse is produced, even when the count later matches either compare value again.
- R6: Control bit 3 chooses the time base: 0 selects `tmr_a` and 1 selects `tmr_b`. Matches on the timer that is not selected have no effect.
- R7: While control bit 15 (enable) is 0, `pulse_o` is held at 0 and compare matches neither move the pulse state nor set the flag.
- R8: `irq_flag_o` stays set until a write to address 3 with bit 0 = 1. A write there with bit 0 = 0 leaves it set, and clearing the flag does not re-arm the pulse.
- R9: `irq_o` is 1 only while `irq_flag_o` is 1 and control bit 5 (interrupt enable) is 1.
- R10: Writing the one-shot mode again re-arms the unit for a new pulse, without stopping or clearing the timer.
- R11: With leading value 0x3000, trailing value 0x3003 and a count that advances by one per clock, `pulse_o` is high for exactly 3 cycles.
- R12: A control write with any mode code other than 3'b100 leaves the output low and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_a | input | CNT_W | Timer count, time base 0 |
| tmr_b | input | CNT_W | Timer count, time base 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 leading compare, 2 trailing compare, 3 flag clear |
| wr_data | input | DATA_W | Write data |
| pulse_o | output | 1 | Single-pulse output |
| irq_flag_o | output | 1 | Sticky trailing-edge flag |
| irq_o | output | 1 | Interrupt request (flag and enable) |

## Verification
The bench sweeps the count through the compare window and counts how many high cycles it sees. A compare that is off by one or registered twice gives a width other than 3. The bench then lets the count pass the compare values again without a new arm, so a unit that does not latch its done state gives a second pulse. It drives matches on the time base that is not selected, and it also sweeps with the enable clear. A broken select or a missing enable gate then shows as a pulse or a flag. Finally it writes a zero to the flag-clear address, leaves the interrupt enable off, and uses a mode code other than one-shot. These catch a flag that clears on any write, an interrupt that ignores its enable, and a unit that arms on any mode.

// File: rtl/sp_ocmp_pkg.sv
`timescale 1ns/1ps
package sp_ocmp_pkg;
   // control word layout
   localparam int unsigned EN_BIT   = 15;
   localparam int unsigned TSEL_BIT = 3;
   localparam int unsigned IE_BIT   = 5;
   localparam int unsigned MODE_LSB = 0;
   localparam int unsigned MODE_W   = 3;
   localparam logic [MODE_W-1:0] MODE_ONESHOT = 3'b100;

   // register addresses
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_LEAD = 2'd1;
   localparam logic [1:0] ADDR_TRAIL = 2'd2;
   localparam logic [1:0] ADDR_FCLR = 2'd3;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ARMED = 2'd1,
      PH_HIGH  = 2'd2,
      PH_DONE  = 2'd3
   } phase_t;
endpackage

// File: rtl/sp_ocmp_regs.sv
`timescale 1ns/1ps
module sp_ocmp_regs
   import sp_ocmp_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ctl_en,
   output logic              ctl_tsel,
   output logic              ctl_ie,
   output logic              ctl_wr,
   output logic              ctl_arm,
   output logic              flag_clr,
   output logic [CNT_W-1:0]  lead_val,
   output logic [CNT_W-1:0]  trail_val
);
   localparam int unsigned MODE_MSB = MODE_LSB + MODE_W - 1;

   generate
      if (DATA_W <= EN_BIT) begin : g_bad_data_w
         $error("sp_ocmp_regs: DATA_W must exceed the enable bit position");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("sp_ocmp_regs: CNT_W must not exceed DATA_W");
      end
   endgenerate

   logic wr_ctrl, wr_lead, wr_trail;
   assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_lead  = wr_en && (wr_addr == ADDR_LEAD);
   assign wr_trail = wr_en && (wr_addr == ADDR_TRAIL);

   assign ctl_wr   = wr_ctrl;
   assign ctl_arm  = wr_ctrl && (wr_data[MODE_MSB:MODE_LSB] == MODE_ONESHOT);
   assign flag_clr = wr_en && (wr_addr == ADDR_FCLR) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en   <= 1'b0;
         ctl_tsel <= 1'b0;
         ctl_ie   <= 1'b0;
      end else if (wr_ctrl) begin
         ctl_en   <= wr_data[EN_BIT];
         ctl_tsel <= wr_data[TSEL_BIT];
         ctl_ie   <= wr_data[IE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_val  <= '0;
         trail_val <= '0;
      end else begin
         if (wr_lead)  lead_val  <= wr_data[CNT_W-1:0];
         if (wr_trail) trail_val <= wr_data[CNT_W-1:0];
      end
   end

   logic unused_data;
   assign unused_data = ^wr_data;
endmodule

// File: rtl/sp_ocmp_match.sv
`timescale 1ns/1ps
module sp_ocmp_match #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned N_TBASE = 2
) (
   input  logic [CNT_W-1:0] tmr_a,
   input  logic [CNT_W-1:0] tmr_b,
   input  logic             sel,
   input  logic [CNT_W-1:0] lead_val,
   input  logic [CNT_W-1:0] trail_val,
   output logic             hit_lead,
   output logic             hit_trail
);
   localparam int unsigned SEL_W = (N_TBASE > 1) ? $clog2(N_TBASE) : 1;

   logic [CNT_W-1:0] base;

   generate
      if (N_TBASE == 2) begin : g_two_bases
         assign base = sel ? tmr_b : tmr_a;
      end else if (N_TBASE == 1) begin : g_one_base
         assign base = tmr_a;
         logic unused_sel;
         assign unused_sel = sel ^ (^tmr_b);
      end else begin : g_bad_bases
         $error("sp_ocmp_match: N_TBASE must be 1 or 2 (select width %0d)", SEL_W);
      end
   endgenerate

   assign hit_lead  = (base == lead_val);
   assign hit_trail = (base == trail_val);
endmodule

// File: rtl/sp_ocmp_fsm.sv
`timescale 1ns/1ps
module sp_ocmp_fsm
   import sp_ocmp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_en,
   input  logic ctl_wr,
   input  logic ctl_arm,
   input  logic flag_clr,
   input  logic hit_lead,
   input  logic hit_trail,
   output logic pulse_o,
   output logic flag_o
);
   phase_t ph_q, ph_d;
   logic   pulse_d, flag_d, trail_evt;

   always_comb begin
      ph_d      = ph_q;
      trail_evt = 1'b0;
      if (ctl_wr) begin
         ph_d = ctl_arm ? PH_ARMED : PH_IDLE;
      end else if (ctl_en) begin
         unique case (ph_q)
            PH_ARMED: if (hit_lead)  ph_d = PH_HIGH;
            PH_HIGH:  if (hit_trail) begin
               ph_d      = PH_DONE;
               trail_evt = 1'b1;
            end
            default: ph_d = ph_q;
         endcase
      end
   end

   assign pulse_d = (ph_d == PH_HIGH) && ctl_en && !ctl_wr;
   assign flag_d  = trail_evt || (flag_o && !flag_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         pulse_o <= 1'b0;
         flag_o  <= 1'b0;
      end else begin
         ph_q    <= ph_d;
         pulse_o <= pulse_d;
         flag_o  <= flag_d;
      end
   end
endmodule

// File: rtl/sp_ocmp.sv
`timescale 1ns/1ps
module sp_ocmp
   import sp_ocmp_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tmr_a,
   input  logic [CNT_W-1:0]  tmr_b,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pulse_o,
   output logic              irq_flag_o,
   output logic              irq_o
);
   logic             ctl_en, ctl_tsel, ctl_ie, ctl_wr, ctl_arm, flag_clr;
   logic             hit_lead, hit_trail;
   logic [CNT_W-1:0] lead_val, trail_val;

   sp_ocmp_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .ctl_en    (ctl_en),
      .ctl_tsel  (ctl_tsel),
      .ctl_ie    (ctl_ie),
      .ctl_wr    (ctl_wr),
      .ctl_arm   (ctl_arm),
      .flag_clr  (flag_clr),
      .lead_val  (lead_val),
      .trail_val (trail_val)
   );

   sp_ocmp_match #(.CNT_W(CNT_W), .N_TBASE(2)) u_match (
      .tmr_a     (tmr_a),
      .tmr_b     (tmr_b),
      .sel       (ctl_tsel),
      .lead_val  (lead_val),
      .trail_val (trail_val),
      .hit_lead  (hit_lead),
      .hit_trail (hit_trail)
   );

   sp_ocmp_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_en    (ctl_en),
      .ctl_wr    (ctl_wr),
      .ctl_arm   (ctl_arm),
      .flag_clr  (flag_clr),
      .hit_lead  (hit_lead),
      .hit_trail (hit_trail),
      .pulse_o   (pulse_o),
      .flag_o    (irq_flag_o)
   );

   assign irq_o = irq_flag_o && ctl_ie;
endmodule

// File: rtl/sp_ocmp_chk.sv
`timescale 1ns/1ps
module sp_ocmp_chk (
   input logic clk,
   input logic rst_n,
   input logic pulse_o,
   input logic irq_flag_o,
   input logic ctl_en,
   input logic ctl_wr,
   input logic flag_clr
);
   // R2: a control write leaves the output low on the next cycle
   a_r2_write_low: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> !pulse_o);

   // R3: a rising edge only follows an enabled cycle
   a_r3_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |-> $past(ctl_en));

   // R4: with no write and enable held, a falling edge comes with the flag
   a_r4_fall_flags: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pulse_o) && $past(ctl_en) && !$past(ctl_wr)) |-> irq_flag_o);

   // R7: disabled means low on the next cycle
   a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |=> !pulse_o);

   // R8: flag holds without a clear
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag_o && !flag_clr) |=> irq_flag_o);
endmodule

bind sp_ocmp sp_ocmp_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pulse_o    (pulse_o),
   .irq_flag_o (irq_flag_o),
   .ctl_en     (ctl_en),
   .ctl_wr     (ctl_wr),
   .flag_clr   (flag_clr)
);

// File: tb/tb_sp_ocmp.sv
`timescale 1ns/1ps
module tb_sp_ocmp;
   localparam int CNT_W = 16;
   localparam int DATA_W = 16;
   localparam logic [15:0] PARK = 16'hAAAA;
   // control word: bit15 enable, bit5 irq enable, bit3 time base, [2:0] mode
   localparam logic [15:0] C_ARM_IE = 16'h8024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CNT_W-1:0] tmr_a = PARK, tmr_b = PARK;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic pulse_o, irq_flag_o, irq_o;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   sp_ocmp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pulse_o(pulse_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // sweep one timer from lo to hi, one step per cycle, count high cycles
   task automatic sweep(input bit use_b, input int lo, input int hi, output int highs);
      highs = 0;
      for (int v = lo; v <= hi; v++) begin
         @(negedge clk);
         highs += int'(pulse_o);
         if (use_b) tmr_b = v[CNT_W-1:0]; else tmr_a = v[CNT_W-1:0];
      end
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         highs += int'(pulse_o);
         if (use_b) tmr_b = PARK; else tmr_a = PARK;
      end
   endtask

   task automatic t_reset;
      chk("R1 pulse", pulse_o, 0);
      chk("R1 flag", irq_flag_o, 0);
      chk("R1 irq", irq_o, 0);
   endtask

   task automatic t_basic;
      int h;
      wr(2'd1, 16'h3000);
      wr(2'd2, 16'h3003);
      wr(2'd0, C_ARM_IE);
      chk("R2 low after arm", pulse_o, 0);
      sweep(1'b0, 16'h2FF8, 16'h3004, h);
      chk("R11 width", h, 3);
      chk("R3 pulse seen", int'(h > 0), 1);
      chk("R4 low after trail", pulse_o, 0);
      chk("R4 flag set", irq_flag_o, 1);
      chk("R9 irq with ie", irq_o, 1);
   endtask

   task automatic t_no_retrigger;
      int h;
      sweep(1'b0, 16'h2FFE, 16'h3005, h);
      chk("R5 no second pulse", h, 0);
   endtask

   task automatic t_flag;
      int h;
      wr(2'd3, 16'h0000);
      chk("R8 zero write keeps flag", irq_flag_o, 1);
      wr(2'd3, 16'h0001);
      chk("R8 flag cleared", irq_flag_o, 0);
      chk("R9 irq follows flag", irq_o, 0);
      sweep(1'b0, 16'h2FFE, 16'h3005, h);
      chk("R8 clear does not rearm", h, 0);
   endtask

   task automatic t_rearm;
      int h;
      wr(2'd0, C_ARM_IE);
      sweep(1'b0, 16'h2FFE, 16'h3005, h);
      chk("R10 rearm pulse", h, 3);
      wr(2'd3, 16'h0001);
   endtask

   task automatic t_tsel;
      int h;
      wr(2'd1, 16'h0010);
      wr(2'd2, 16'h0015);
      wr(2'd0, C_ARM_IE | 16'h0008);
      sweep(1'b0, 16'h000E, 16'h0017, h);
      chk("R6 unselected timer ignored", h, 0);
      chk("R6 unselected no flag", irq_flag_o, 0);
      sweep(1'b1, 16'h000E, 16'h0017, h);
      chk("R6 selected timer pulses", h, 5);
      wr(2'd3, 16'h0001);
   endtask

   task automatic t_disable;
      int h;
      wr(2'd0, 16'h0024);
      sweep(1'b0, 16'h000E, 16'h0017, h);
      chk("R7 disabled no pulse", h, 0);
      chk("R7 disabled no flag", irq_flag_o, 0);
      wr(2'd0, C_ARM_IE);
      sweep(1'b0, 16'h000E, 16'h0017, h);
      chk("R7 enabled pulse", h, 5);
      wr(2'd3, 16'h0001);
   endtask

   task automatic t_no_ie;
      int h;
      wr(2'd0, 16'h8004);
      sweep(1'b0, 16'h000E, 16'h0017, h);
      chk("R9 flag without ie", irq_flag_o, 1);
      chk("R9 irq masked", irq_o, 0);
      wr(2'd3, 16'h0001);
   endtask

   task automatic t_other_mode;
      int h;
      wr(2'd0, 16'h8025);
      chk("R12 low after write", pulse_o, 0);
      sweep(1'b0, 16'h000E, 16'h0017, h);
      chk("R12 no pulse", h, 0);
      chk("R12 no flag", irq_flag_o, 0);
   endtask

   task automatic finish_run;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_no_retrigger();
      t_flag();
      t_rearm();
      t_tsel();
      t_disable();
      t_no_ie();
      t_other_mode();
      finish_run();
   end
endmodule